// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register face of one channel of a scatter-gather DMA engine. Software reaches it over a small byte-addressed register bus with separate write strobe, read strobe, address and data. A setup register holds the two interrupt enables, the transfer direction and a mode that tolerates descriptors already marked as used. Five status registers each record one kind of engine event in bit 0: used-descriptor hit, invalid-descriptor hit, FIFO overflow, FIFO underflow and buffer complete. The engine sends each event as a one-cycle pulse.

The block drives a single interrupt line and a pause request back to the engine. The pause request is raised by an overflow or an underflow and held until software has cleared both of those flags. Software can also read the engine's current buffer ID, the byte offset of its next access, and the read-FIFO fill level. The fill level is capped at 1020 bytes and has its own empty indicator.

Registers are 16 bits wide on read. Writes take their value from an 8-bit data bus. The address map is: 0x00 setup, 0x01 used status, 0x02 invalid status, 0x03 overflow status, 0x04 underflow status, 0x05 complete status, 0x06 buffer ID, 0x08 byte offset and 0x0A FIFO level.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset the setup register, all five status flags, `irq` and `pause_req` are 0.
- R2: The setup register keeps written bits 3:0 and reads its upper bits as 0. Bit 0 is the completion interrupt enable and bit 1 is the error interrupt enable. Bit 2 is the direction and appears on `cfg_to_host`, where 1 means board to host bus. Bit 3 is ignore-used and appears on `cfg_ignore_used`.
- R3: A pulse on any event input sets bit 0 of its status register on the next clock edge, even when the error interrupt enable is 0.
- R4: While ignore-used (setup bit 3) is 1, a used-descriptor event leaves the used status flag at 0.
- R5: A status flag clears only when the value 0x00 is written to its address. Writing any nonzero value leaves it unchanged.
- R6: If an event and a clearing write to the same status register fall in one cycle, the flag ends up set.
- R7: `irq` is 1 exactly when either (a) the complete flag and enable bit 0 are both set, or (b) enable bit 1 is set and at least one of the used, invalid, overflow or underflow flags is set.
- R8: `pause_req` goes high after an overflow or underflow event. It stays high until both of those status flags have been cleared.
- R9: The FIFO level register (0x0A) holds the byte count in bits 9:0, saturated at 0x3FC (1020). Bit 15 is 1 when the count is zero, and all other bits read 0.
- R10: The buffer ID (0x06) and byte offset (0x08) registers read the engine's live values. Writes to them have no effect.
- R11: `rd_data` is 0 when `reg_rd` is low or when the address is not mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 16 | Read data, combinational |
| ev_used | input | 1 | Engine hit a descriptor already marked used |
| ev_invalid | input | 1 | Engine hit a descriptor marked invalid |
| ev_overflow | input | 1 | FIFO overflow |
| ev_underflow | input | 1 | FIFO underflow |
| ev_complete | input | 1 | Buffer filled with completion notify |
| cur_buf_id | input | BUF_ID_W (8) | Buffer ID for the next access |
| cur_offset | input | OFFS_W (16) | Byte offset for the next access |
| fifo_bytes | input | FIFO_CNT_W (12) | Raw read-FIFO byte count |
| irq | output | 1 | Interrupt request |
| pause_req | output | 1 | Pause request to the engine |
| cfg_to_host | output | 1 | Direction: 1 board to host, 0 host to board |
| cfg_ignore_used | output | 1 | Ignore-used mode to the engine |

## Verification
The two functions that can fall in the same cycle are the engine setting a status flag and software clearing that flag with a zero write. The bench provokes this by raising an event pulse and the clearing write on the same falling edge, so that both are sampled by one rising edge. The result is judged by reading the flag back: it must still be 1. In the same way, the bench clears overflow while underflow is still set and checks that the pause request does not drop too early.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int ADDR_W   = 5;
  localparam int NUM_STAT = 5;
  localparam int LEVEL_W  = 10;
  localparam int LEVEL_MAX = 1020;

  localparam logic [ADDR_W-1:0] A_SETUP = 5'h00;
  localparam logic [ADDR_W-1:0] A_USED  = 5'h01;
  localparam logic [ADDR_W-1:0] A_INVAL = 5'h02;
  localparam logic [ADDR_W-1:0] A_OVF   = 5'h03;
  localparam logic [ADDR_W-1:0] A_UNF   = 5'h04;
  localparam logic [ADDR_W-1:0] A_DONE  = 5'h05;
  localparam logic [ADDR_W-1:0] A_BUFID = 5'h06;
  localparam logic [ADDR_W-1:0] A_OFFS  = 5'h08;
  localparam logic [ADDR_W-1:0] A_LEVEL = 5'h0A;

  // status vector index
  localparam int S_USED  = 0;
  localparam int S_INVAL = 1;
  localparam int S_OVF   = 2;
  localparam int S_UNF   = 3;
  localparam int S_DONE  = 4;

  typedef struct packed {
    logic ignore_used;
    logic to_host;
    logic err_ie;
    logic done_ie;
  } setup_t;

  // address of the status register for a given index
  function automatic logic [ADDR_W-1:0] stat_addr(int idx);
    return ADDR_W'(A_USED + idx);
  endfunction

  // fill level capped to the readout range
  function automatic logic [LEVEL_W-1:0] level_sat(int unsigned n);
    if (n > LEVEL_MAX) return LEVEL_W'(LEVEL_MAX);
    return LEVEL_W'(n);
  endfunction
endpackage

// File: rtl/dma_csr_setup.sv
module dma_csr_setup
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output setup_t            setup_q
);
  logic hit;
  assign hit = wr_en && (wr_addr == A_SETUP);

  always_ff @(posedge clk) begin
    if (!rst_n) setup_q <= '0;
    else if (hit) setup_q <= setup_t'(wr_data[3:0]);
  end
endmodule

// File: rtl/dma_csr_sticky.sv
module dma_csr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  // set dominates clear
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end
endmodule

// File: rtl/dma_csr_level.sv
module dma_csr_level
  import dma_csr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [15:0]      level_word
);
  localparam int PAD_W = 16 - 1 - LEVEL_W;
  logic empty;
  logic [LEVEL_W-1:0] capped;

  assign empty  = (cnt == '0);
  assign capped = level_sat(int'(unsigned'(cnt)));
  assign level_word = {empty, {PAD_W{1'b0}}, capped};
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
#(
  parameter int BUF_ID_W   = 8,
  parameter int OFFS_W     = 16,
  parameter int FIFO_CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            wr_data,
  output logic [15:0]           rd_data,
  input  logic                  ev_used,
  input  logic                  ev_invalid,
  input  logic                  ev_overflow,
  input  logic                  ev_underflow,
  input  logic                  ev_complete,
  input  logic [BUF_ID_W-1:0]   cur_buf_id,
  input  logic [OFFS_W-1:0]     cur_offset,
  input  logic [FIFO_CNT_W-1:0] fifo_bytes,
  output logic                  irq,
  output logic                  pause_req,
  output logic                  cfg_to_host,
  output logic                  cfg_ignore_used
);
  setup_t                setup_q;
  logic [NUM_STAT-1:0]   ev_vec;
  logic [NUM_STAT-1:0]   set_vec;
  logic [NUM_STAT-1:0]   clr_vec;
  logic [NUM_STAT-1:0]   stat_q;
  logic [15:0]           level_word;
  logic                  zero_wr;
  logic                  err_any;

  assign ev_vec = {ev_complete, ev_underflow, ev_overflow, ev_invalid, ev_used};

  dma_csr_setup u_setup (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_addr (reg_addr),
    .wr_data (wr_data),
    .setup_q (setup_q)
  );

  assign zero_wr = reg_wr && (wr_data == 8'h00);

  for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
    if (g == S_USED) begin : g_used
      assign set_vec[g] = ev_vec[g] && !setup_q.ignore_used;
    end else begin : g_plain
      assign set_vec[g] = ev_vec[g];
    end
    assign clr_vec[g] = zero_wr && (reg_addr == stat_addr(g));

    dma_csr_sticky u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_q (stat_q[g])
    );
  end

  dma_csr_level #(.CNT_W(FIFO_CNT_W)) u_level (
    .cnt        (fifo_bytes),
    .level_word (level_word)
  );

  assign err_any = stat_q[S_USED] | stat_q[S_INVAL] | stat_q[S_OVF] | stat_q[S_UNF];
  assign irq = (setup_q.done_ie & stat_q[S_DONE]) | (setup_q.err_ie & err_any);
  assign pause_req = stat_q[S_OVF] | stat_q[S_UNF];

  assign cfg_to_host     = setup_q.to_host;
  assign cfg_ignore_used = setup_q.ignore_used;

  always_comb begin
    rd_data = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_SETUP: rd_data = {12'h000, setup_q};
        A_USED:  rd_data = {15'h0000, stat_q[S_USED]};
        A_INVAL: rd_data = {15'h0000, stat_q[S_INVAL]};
        A_OVF:   rd_data = {15'h0000, stat_q[S_OVF]};
        A_UNF:   rd_data = {15'h0000, stat_q[S_UNF]};
        A_DONE:  rd_data = {15'h0000, stat_q[S_DONE]};
        A_BUFID: rd_data = 16'(cur_buf_id);
        A_OFFS:  rd_data = 16'(cur_offset);
        A_LEVEL: rd_data = level_word;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk
  import dma_csr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [7:0]          wr_data,
  input logic [NUM_STAT-1:0] ev_vec,
  input logic [NUM_STAT-1:0] stat_q,
  input logic                ignore_used,
  input logic                irq,
  input logic                pause_req,
  input logic [15:0]         level_word
);
  // R3
  ovf_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[S_OVF] |=> stat_q[S_OVF]);

  // R4
  ignore_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ignore_used && ev_vec[S_USED] && !stat_q[S_USED]) |=> !stat_q[S_USED]);

  // R5
  zero_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_OVF && wr_data == 8'h00 && !ev_vec[S_OVF]) |=> !stat_q[S_OVF]);

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_DONE && ev_vec[S_DONE]) |=> stat_q[S_DONE]);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0));

  // R8
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && !(reg_wr && wr_data == 8'h00 && (reg_addr == A_OVF || reg_addr == A_UNF)))
      |=> pause_req);

  // R9
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_word[LEVEL_W-1:0] <= LEVEL_W'(LEVEL_MAX));
endmodule

bind dma_chan_csr dma_chan_csr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .wr_data     (wr_data),
  .ev_vec      (ev_vec),
  .stat_q      (stat_q),
  .ignore_used (cfg_ignore_used),
  .irq         (irq),
  .pause_req   (pause_req),
  .level_word  (level_word)
);

// File: tb/test_dma_chan_csr.sv
module test_dma_chan_csr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_data;
  logic [4:0]  ev = '0; // {complete, underflow, overflow, invalid, used}
  logic [7:0]  cur_buf_id = '0;
  logic [15:0] cur_offset = '0;
  logic [11:0] fifo_bytes = '0;
  logic        irq, pause_req, cfg_to_host, cfg_ignore_used;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk; // 50 MHz

  dma_chan_csr i_dma_chan_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .ev_used(ev[0]), .ev_invalid(ev[1]), .ev_overflow(ev[2]),
    .ev_underflow(ev[3]), .ev_complete(ev[4]),
    .cur_buf_id(cur_buf_id), .cur_offset(cur_offset), .fifo_bytes(fifo_bytes),
    .irq(irq), .pause_req(pause_req), .cfg_to_host(cfg_to_host),
    .cfg_ignore_used(cfg_ignore_used)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; wr_data = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] v);
    reg_rd = 1; reg_addr = a;
    #1 v = rd_data;
    reg_rd = 0;
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    ev[idx] = 1'b1;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic clear_all();
    for (int i = 1; i <= 5; i++) wr(5'(i), 8'h00);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(5'h00, v); check("R1 setup", v, 16'h0);
    for (int i = 1; i <= 5; i++) begin
      rd(5'(i), v); check("R1 status", v, 16'h0);
    end
    check("R1 irq", 16'(irq), 16'h0);
    check("R1 pause", 16'(pause_req), 16'h0);
  endtask

  task automatic t_setup();
    logic [15:0] v;
    wr(5'h00, 8'hFF);
    rd(5'h00, v); check("R2 setup readback", v, 16'h000F);
    check("R2 direction out", 16'(cfg_to_host), 16'h1);
    check("R2 ignore out", 16'(cfg_ignore_used), 16'h1);
    wr(5'h00, 8'h04);
    rd(5'h00, v); check("R2 setup readback 4", v, 16'h0004);
    check("R2 ignore off", 16'(cfg_ignore_used), 16'h0);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_events();
    logic [15:0] v;
    for (int i = 0; i < 5; i++) begin
      pulse(i);
      rd(5'(i + 1), v); check("R3 flag set with enables off", v, 16'h1);
    end
    check("R7 no irq with enables off", 16'(irq), 16'h0);
    clear_all();
    check("R8 pause cleared", 16'(pause_req), 16'h0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    pulse(4);
    wr(5'h05, 8'h01);
    rd(5'h05, v); check("R5 nonzero write keeps flag", v, 16'h1);
    wr(5'h05, 8'h80);
    rd(5'h05, v); check("R5 write 0x80 keeps flag", v, 16'h1);
    wr(5'h05, 8'h00);
    rd(5'h05, v); check("R5 zero write clears", v, 16'h0);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    wr(5'h00, 8'h08);
    pulse(0);
    rd(5'h01, v); check("R4 used suppressed", v, 16'h0);
    wr(5'h00, 8'h00);
    pulse(0);
    rd(5'h01, v); check("R4 used latches when mode off", v, 16'h1);
    wr(5'h01, 8'h00);
  endtask

  task automatic t_irq();
    wr(5'h00, 8'h01);
    pulse(4);
    check("R7 irq on complete", 16'(irq), 16'h1);
    wr(5'h05, 8'h00);
    check("R7 irq drops on clear", 16'(irq), 16'h0);
    pulse(1);
    check("R7 error without err enable", 16'(irq), 16'h0);
    wr(5'h00, 8'h02);
    check("R7 irq on error enable", 16'(irq), 16'h1);
    wr(5'h02, 8'h00);
    check("R7 irq low after clear", 16'(irq), 16'h0);
    wr(5'h00, 8'h00);
  endtask

  task automatic t_pause();
    pulse(2);
    check("R8 pause on overflow", 16'(pause_req), 16'h1);
    pulse(3);
    wr(5'h03, 8'h00);
    check("R8 pause held by underflow", 16'(pause_req), 16'h1);
    wr(5'h04, 8'h00);
    check("R8 pause released", 16'(pause_req), 16'h0);
  endtask

  task automatic t_race();
    logic [15:0] v;
    @(negedge clk);
    reg_wr = 1; reg_addr = 5'h05; wr_data = 8'h00; ev[4] = 1'b1;
    @(negedge clk);
    reg_wr = 0; ev = '0;
    rd(5'h05, v); check("R6 event wins over clear", v, 16'h1);
    @(negedge clk);
    reg_wr = 1; reg_addr = 5'h03; wr_data = 8'h00; ev[2] = 1'b1;
    @(negedge clk);
    reg_wr = 0; ev = '0;
    rd(5'h03, v); check("R6 overflow wins over clear", v, 16'h1);
    clear_all();
  endtask

  task automatic t_level();
    logic [15:0] v;
    fifo_bytes = 12'd0;    rd(5'h0A, v); check("R9 empty", v, 16'h8000);
    fifo_bytes = 12'd5;    rd(5'h0A, v); check("R9 small", v, 16'h0005);
    fifo_bytes = 12'd1019; rd(5'h0A, v); check("R9 1019", v, 16'd1019);
    fifo_bytes = 12'd1020; rd(5'h0A, v); check("R9 at cap", v, 16'h03FC);
    fifo_bytes = 12'd1021; rd(5'h0A, v); check("R9 above cap", v, 16'h03FC);
    fifo_bytes = 12'd4000; rd(5'h0A, v); check("R9 far above cap", v, 16'h03FC);
  endtask

  task automatic t_ro();
    logic [15:0] v;
    cur_buf_id = 8'h5A; cur_offset = 16'h1234;
    wr(5'h06, 8'hFF); wr(5'h08, 8'h00);
    rd(5'h06, v); check("R10 buffer id", v, 16'h005A);
    rd(5'h08, v); check("R10 offset", v, 16'h1234);
    rd(5'h00, v); check("R10 setup untouched", v, 16'h0000);
  endtask

  task automatic t_rdzero();
    pulse(4);
    reg_addr = 5'h05; #1;
    check("R11 no read strobe", rd_data, 16'h0);
    begin
      logic [15:0] v;
      rd(5'h1F, v); check("R11 unmapped", v, 16'h0);
    end
    wr(5'h05, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_setup();
    t_events();
    t_clear();
    t_ignore();
    t_irq();
    t_pause();
    t_race();
    t_level();
    t_ro();
    t_rdzero();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule